// File: doc/BRIEF.md
# Debounced Selectable Nibble Incrementer

This block keeps a 16-bit value made of four independent 4-bit fields and bumps one of them each time a push-button is pressed. A 2-bit select input names the field. The raw button is assumed to bounce and to arrive with no timing relation to the system clock. It is therefore brought into the clock domain by a two-stage synchronizer. A counter-based filter then accepts a new level only after the synchronized input has held steady for a set number of cycles. An edge detector turns each accepted press into one pulse, one clock cycle wide.

Every register runs on the single system clock. The button never acts as a clock. The pulse is also driven out, so that neighbouring logic can see each accepted press. Fields never carry into one another. There is no data stream, so all pins are plain control and status signals with no handshake.

Top module: `nibble_bump_top`

## Requirements
- R1: While `rst` is high at a clock edge, `value` becomes 0x0000 and `press_pulse` is 0 in the cycle that follows.
- R2: An accepted press increments only the selected field: `field_sel` 0 selects bits 3:0, 1 selects bits 7:4, 2 selects bits 11:8 and 3 selects bits 15:12. `field_sel` is sampled in the cycle in which `press_pulse` is high.
- R3: A selected field holding 0xF wraps to 0x0, and the next field up is unchanged (no carry).
- R4: A high level on `btn_raw` that lasts fewer than `DEBOUNCE_CYC` cycles produces no pulse and leaves `value` unchanged.
- R5: Each accepted press gives exactly one `press_pulse` that is one cycle wide. A press held for any length of time gives one increment only. A further increment needs a debounced release followed by a new press.
- R6: Changing `field_sel` while no press is pulsing leaves `value` unchanged.
- R7: `value` changes only at the edge that ends a cycle in which `press_pulse` is high.
- R8: If `btn_raw` rises and then holds steady, `press_pulse` goes high in the cycle after the `DEBOUNCE_CYC`+2-th clock edge counted from the rise. That is 2 synchronizer stages plus `DEBOUNCE_CYC` stable cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw | input | 1 | Raw push-button, active high, asynchronous and bouncing |
| field_sel | input | 2 | Selects the 4-bit field that a press increments |
| value | output | 16 | The four-field value |
| press_pulse | output | 1 | One-cycle pulse for each accepted press |

## Verification
The bench builds the block with `DEBOUNCE_CYC` set to 8 instead of the default one million. This makes the exact pulse latency, glitches just shorter than the window, and long holds all cheap enough to drive one cycle at a time. With this short window the bench can walk every field through its wrap from 0xF and still check the neighbouring field for a carry. The default window uses the same counter logic and differs only in its terminal count.

// File: rtl/nibble_bump_pkg.sv
package nibble_bump_pkg;
  localparam int FIELD_W  = 4;
  localparam int N_FIELDS = 4;
  localparam int VALUE_W  = FIELD_W * N_FIELDS;
  localparam int SEL_W    = $clog2(N_FIELDS);

  typedef logic [VALUE_W-1:0] value_t;
  typedef logic [FIELD_W-1:0] field_t;
  typedef logic [SEL_W-1:0]   sel_t;

  function automatic field_t get_field(value_t v, sel_t s);
    return v[s*FIELD_W +: FIELD_W];
  endfunction

  function automatic value_t field_mask(sel_t s);
    value_t m;
    m = '0;
    m[s*FIELD_W +: FIELD_W] = '1;
    return m;
  endfunction
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/level_filter.sv
module level_filter #(
  parameter int DEBOUNCE_CYC = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level
);
  localparam int CW = (DEBOUNCE_CYC < 2) ? 1 : $clog2(DEBOUNCE_CYC);
  localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b0;
      cnt   <= '0;
    end else if (din == level) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      level <= din;
      cnt   <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R4
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(level) |-> ($past(cnt) == LAST && $past(din) != $past(level)));
endmodule

// File: rtl/rise_pulse.sv
module rise_pulse (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic pulse
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= level;
  end

  assign pulse = level & ~prev;

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/nibble_bump_top.sv
module nibble_bump_top
  import nibble_bump_pkg::*;
#(
  parameter int DEBOUNCE_CYC = 1000000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        btn_raw,
  input  logic [1:0]  field_sel,
  output logic [15:0] value,
  output logic        press_pulse
);
  logic btn_s, btn_lvl;
  value_t val_q;

  btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(btn_raw), .q_sync(btn_s));

  level_filter #(.DEBOUNCE_CYC(DEBOUNCE_CYC)) u_filt (
    .clk(clk), .rst(rst), .din(btn_s), .level(btn_lvl));

  rise_pulse u_edge (
    .clk(clk), .rst(rst), .level(btn_lvl), .pulse(press_pulse));

  generate
    for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
      always_ff @(posedge clk) begin
        if (rst)
          val_q[f*FIELD_W +: FIELD_W] <= '0;
        else if (press_pulse && field_sel == sel_t'(f))
          val_q[f*FIELD_W +: FIELD_W] <= val_q[f*FIELD_W +: FIELD_W] + 1'b1;
      end
    end
  endgenerate

  assign value = val_q;

  // R2
  bump_sel_chk: assert property (@(posedge clk) disable iff (rst)
    press_pulse |=> get_field(value, $past(field_sel)) ==
                    field_t'(get_field($past(value), $past(field_sel)) + 1'b1));

  // R3
  no_carry_chk: assert property (@(posedge clk) disable iff (rst)
    press_pulse |=> (value & ~field_mask($past(field_sel))) ==
                    ($past(value) & ~field_mask($past(field_sel))));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !press_pulse |=> $stable(value));
endmodule

// File: tb/sim_nibble_bump_top.sv
module sim_nibble_bump_top;
  localparam int DB = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_raw = 1'b0;
  logic [1:0] field_sel = 2'd0;
  logic [15:0] value;
  logic press_pulse;

  int n_chk = 0;
  int n_bad = 0;
  int pulses = 0;
  logic [15:0] model = 16'h0;

  always #2.5 clk = ~clk;

  nibble_bump_top #(.DEBOUNCE_CYC(DB)) u0 (
    .clk(clk), .rst(rst), .btn_raw(btn_raw), .field_sel(field_sel),
    .value(value), .press_pulse(press_pulse));

  always @(posedge clk) if (!rst && press_pulse) pulses <= pulses + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // full press and release, updating the model
  task automatic press(input logic [1:0] s);
    int p0;
    field_sel = s;
    p0 = pulses;
    btn_raw = 1'b1;
    cycles(DB + 6);
    btn_raw = 1'b0;
    cycles(DB + 6);
    check("R5 one pulse per press", pulses - p0, 1);
    model[s*4 +: 4] = model[s*4 +: 4] + 4'd1;
    check("R2 selected field bump", value, model);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    cycles(3);
    check("R1 value after reset", value, 16'h0000);
    check("R1 pulse after reset", press_pulse, 0);
    rst = 1'b0;
    model = 16'h0;
    cycles(2);
  endtask

  task automatic t_latency();
    int n;
    logic wide;
    field_sel = 2'd1;
    btn_raw = 1'b1;
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!press_pulse && n < 100);
    check("R8 pulse latency", n, DB + 2);
    @(negedge clk);
    wide = press_pulse;
    check("R5 pulse one cycle wide", wide, 0);
    cycles(40);
    btn_raw = 1'b0;
    cycles(DB + 6);
    model[7:4] = model[7:4] + 4'd1;
    check("R5 long hold one increment", value, model);
  endtask

  task automatic t_glitch();
    int p0;
    p0 = pulses;
    field_sel = 2'd0;
    for (int g = 1; g < DB; g++) begin
      btn_raw = 1'b1; cycles(g);
      btn_raw = 1'b0; cycles(DB + 4);
    end
    check("R4 short glitch no pulse", pulses - p0, 0);
    check("R4 short glitch value", value, model);
  endtask

  task automatic t_bounce();
    int p0;
    p0 = pulses;
    field_sel = 2'd2;
    for (int b = 0; b < 5; b++) begin
      btn_raw = 1'b1; cycles(3);
      btn_raw = 1'b0; cycles(2);
    end
    btn_raw = 1'b1; cycles(DB + 6);
    for (int b = 0; b < 4; b++) begin
      btn_raw = 1'b0; cycles(2);
      btn_raw = 1'b1; cycles(3);
    end
    btn_raw = 1'b0; cycles(DB + 6);
    check("R5 bouncing press single pulse", pulses - p0, 1);
    model[11:8] = model[11:8] + 4'd1;
    check("R5 bouncing press value", value, model);
  endtask

  task automatic t_sel_idle();
    for (int s = 0; s < 4; s++) begin
      field_sel = 2'(s);
      cycles(3);
    end
    check("R6 select change no effect", value, model);
    check("R7 no pulse no change", press_pulse, 0);
  endtask

  task automatic t_wrap();
    for (int f = 0; f < 4; f++) begin
      while (model[f*4 +: 4] != 4'hF) press(2'(f));
      press(2'(f));
      check("R3 wrap to zero", value[f*4 +: 4], 4'h0);
    end
    check("R3 no carry whole value", value, model);
  endtask

  initial begin
    t_reset();
    press(2'd0);
    press(2'd3);
    press(2'd3);
    t_latency();
    t_glitch();
    t_bounce();
    t_sel_idle();
    t_wrap();
    press(2'd1);
    t_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule